// File: doc/BRIEF.md
# Mixed-Policy SAR Conversion Sequencer

This block is the digital half of a 12-bit differential charge-redistribution converter. After a start pulse it takes one comparator verdict per valid strobe, fills the result from the top bit down, and sets the bottom-plate switch of every capacitor on the positive and negative arrays. The switching rule depends on where a bit sits in the code. The top bits use capacitors split into two equal halves. These halves first straddle the two references, which gives the mid-supply level, and then merge onto one reference. The next bit lowers one capacitor. Every bit below that raises one capacitor.

While the block is idle, which is the sampling phase, every switch stays at its rest pattern. A one-clock done strobe marks the finished code. The block then returns to idle and waits for the next start. The analog array, the comparator and the references sit outside it.

Top module: `csar_ctrl`

## Requirements
- R1: After reset and throughout idle, every switch control is at rest. Each split pair has half A (even index) = 1 and half B (odd index) = 0 on both arrays. The mono capacitor of bit NBITS-N_CM-1 is 1 on both arrays. Every other mono capacitor is 0 on both arrays. done_o is 0. Here 1 means top reference and 0 means bottom reference.
- R2: Each strobe on cmp_vld_i during a conversion decides exactly one bit, starting at bit NBITS-1 and going down to bit 0, and that bit takes the value of cmp_i. A cycle without the strobe changes no switch control.
- R3: Deciding split bit b with value d drives both halves of its positive pair to ~d and both halves of its negative pair to d. The pair for bit b sits at indices 2*(b-(NBITS-N_CM)) and the index above it.
- R4: Deciding bit NBITS-N_CM-1 with d=1 drops mono_p_o of that bit to 0. With d=0 it drops mono_n_o of that bit to 0.
- R5: Deciding a lower bit b with d=1 raises mono_n_o[b] to 1. With d=0 it raises mono_p_o[b] to 1.
- R6: The clock after the last decision carries done_o=1 together with the full code on result_o, and the switches still hold their final settings. On the next clock done_o is 0, the switches are back at rest, and result_o keeps the code.
- R7: A start pulse during a conversion or during the done cycle is ignored.
- R8: A strobe on cmp_vld_i while idle is ignored.
- R9: A synchronous reset during a conversion returns the block to idle with every switch at rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion start pulse |
| cmp_i | input | 1 | Comparator verdict, 1 when the positive side is higher |
| cmp_vld_i | input | 1 | Comparator verdict valid strobe |
| split_p_o | output | 2*N_CM | Positive-array split half controls |
| split_n_o | output | 2*N_CM | Negative-array split half controls |
| mono_p_o | output | NBITS-N_CM | Positive-array single capacitor controls, indexed by code bit |
| mono_n_o | output | NBITS-N_CM | Negative-array single capacitor controls, indexed by code bit |
| result_o | output | NBITS | Converted code |
| done_o | output | 1 | One-clock completion strobe |

## Verification
Two pairs of events can land on the same clock. A start pulse can meet a decision strobe or the done cycle, and the return to rest can meet a stray strobe in the first idle cycle. The bench runs all 4096 codes with the comparator answering from the target code. It inserts strobe-free gaps with stray starts at varied bit positions. On some codes it raises start during the done cycle and then feeds a strobe. After every decision, the full switch vector is compared with values derived arithmetically from the code bits decided so far. A wrongly accepted start or strobe shows up as a changed pair or capacitor.

// File: rtl/csar_pkg.sv
package csar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_DONE = 2'd2
   } csar_state_e;
endpackage

// File: rtl/csar_seq.sv
module csar_seq
   import csar_pkg::*;
#(
   parameter int NBITS = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             cmp_vld_i,
   output logic [NBITS-1:0] sel_o,
   output logic             hold_o,
   output logic             done_o
);
   localparam int PTR_W = $clog2(NBITS);
   localparam logic [PTR_W-1:0] TOP_PTR = PTR_W'(NBITS - 1);

   csar_state_e      state_q;
   logic [PTR_W-1:0] ptr_q;
   logic             decide;
   logic             last;

   assign decide = (state_q == ST_CONV) && cmp_vld_i;
   assign last   = (ptr_q == '0);
   assign hold_o = (state_q != ST_CONV);
   assign done_o = (state_q == ST_DONE);

   for (genvar g = 0; g < NBITS; g++) begin : g_sel
      assign sel_o[g] = decide && (ptr_q == PTR_W'(g));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         ptr_q   <= TOP_PTR;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_CONV;
               ptr_q   <= TOP_PTR;
            end
            ST_CONV: if (cmp_vld_i) begin
               if (last) state_q <= ST_DONE;
               else      ptr_q   <= ptr_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
   a_r7_start_ignored_conv: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_CONV && start_i && !(decide && last)) |=> (state_q == ST_CONV));
   a_r7_start_ignored_done: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DONE) |=> (state_q == ST_IDLE));
   a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
      (decide && !last) |=> (ptr_q == $past(ptr_q) - 1'b1));
   a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_o));
endmodule

// File: rtl/csar_split_slice.sv
module csar_split_slice (
   input  logic       clk,
   input  logic       rst,
   input  logic       hold_i,
   input  logic       sel_i,
   input  logic       cmp_i,
   output logic [1:0] p_sw_o,
   output logic [1:0] n_sw_o
);
   localparam logic [1:0] PAIR_REST = 2'b01;

   always_ff @(posedge clk) begin
      if (rst || hold_i) begin
         p_sw_o <= PAIR_REST;
         n_sw_o <= PAIR_REST;
      end else if (sel_i) begin
         p_sw_o <= {2{~cmp_i}};
         n_sw_o <= {2{cmp_i}};
      end
   end

   a_r3_pair_merged: assert property (@(posedge clk) disable iff (rst)
      sel_i |=> (p_sw_o[0] == p_sw_o[1]) && (n_sw_o[0] == n_sw_o[1]) && (p_sw_o != n_sw_o));
   a_r1_pair_rest: assert property (@(posedge clk) disable iff (rst)
      hold_i |=> (p_sw_o == PAIR_REST) && (n_sw_o == PAIR_REST));
   a_r2_pair_quiet: assert property (@(posedge clk) disable iff (rst)
      (!hold_i && !sel_i) |=> $stable({p_sw_o, n_sw_o}));
endmodule

// File: rtl/csar_mono_slice.sv
module csar_mono_slice #(
   parameter bit FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic hold_i,
   input  logic sel_i,
   input  logic cmp_i,
   output logic p_sw_o,
   output logic n_sw_o
);
   localparam logic REST = FALLING;

   if (FALLING) begin : g_fall
      always_ff @(posedge clk) begin
         if (rst || hold_i) begin
            p_sw_o <= REST;
            n_sw_o <= REST;
         end else if (sel_i) begin
            if (cmp_i) p_sw_o <= 1'b0;
            else       n_sw_o <= 1'b0;
         end
      end
      a_r4_single_fall: assert property (@(posedge clk) disable iff (rst)
         sel_i |=> ($countones({p_sw_o, n_sw_o}) == 1));
   end else begin : g_rise
      always_ff @(posedge clk) begin
         if (rst || hold_i) begin
            p_sw_o <= REST;
            n_sw_o <= REST;
         end else if (sel_i) begin
            if (cmp_i) n_sw_o <= 1'b1;
            else       p_sw_o <= 1'b1;
         end
      end
      a_r5_single_rise: assert property (@(posedge clk) disable iff (rst)
         sel_i |=> ($countones({p_sw_o, n_sw_o}) == 1));
   end

   a_r1_mono_rest: assert property (@(posedge clk) disable iff (rst)
      hold_i |=> (p_sw_o == REST) && (n_sw_o == REST));
   a_r2_mono_quiet: assert property (@(posedge clk) disable iff (rst)
      (!hold_i && !sel_i) |=> $stable({p_sw_o, n_sw_o}));
endmodule

// File: rtl/csar_ctrl.sv
module csar_ctrl #(
   parameter int NBITS = 12,
   parameter int N_CM  = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start_i,
   input  logic                  cmp_i,
   input  logic                  cmp_vld_i,
   output logic [2*N_CM-1:0]     split_p_o,
   output logic [2*N_CM-1:0]     split_n_o,
   output logic [NBITS-N_CM-1:0] mono_p_o,
   output logic [NBITS-N_CM-1:0] mono_n_o,
   output logic [NBITS-1:0]      result_o,
   output logic                  done_o
);
   localparam int N_MONO = NBITS - N_CM;
   localparam int FALL_BIT = N_MONO - 1;

   if (N_CM < 1 || NBITS < N_CM + 2) begin : g_bad_cfg
      $error("csar_ctrl: need N_CM >= 1 and NBITS >= N_CM + 2");
   end

   logic [NBITS-1:0] sel;
   logic             hold;
   logic [NBITS-1:1] code_q;

   csar_seq #(.NBITS(NBITS)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start_i),
      .cmp_vld_i (cmp_vld_i),
      .sel_o     (sel),
      .hold_o    (hold),
      .done_o    (done_o)
   );

   for (genvar j = 0; j < N_CM; j++) begin : g_split
      csar_split_slice u_pair (
         .clk    (clk),
         .rst    (rst),
         .hold_i (hold),
         .sel_i  (sel[N_MONO + j]),
         .cmp_i  (cmp_i),
         .p_sw_o (split_p_o[2*j +: 2]),
         .n_sw_o (split_n_o[2*j +: 2])
      );
   end

   for (genvar b = 0; b < N_MONO; b++) begin : g_mono
      csar_mono_slice #(.FALLING(b == FALL_BIT)) u_cap (
         .clk    (clk),
         .rst    (rst),
         .hold_i (hold),
         .sel_i  (sel[b]),
         .cmp_i  (cmp_i),
         .p_sw_o (mono_p_o[b]),
         .n_sw_o (mono_n_o[b])
      );
   end

   for (genvar b = 1; b < NBITS; b++) begin : g_code
      always_ff @(posedge clk) begin
         if (sel[b]) code_q[b] <= cmp_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         result_o <= '0;
      else if (sel[0]) result_o <= {code_q, cmp_i};
   end

   a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
      done_o |=> $stable(result_o));
   a_r6_done_after_lsb: assert property (@(posedge clk) disable iff (rst)
      sel[0] |=> done_o);
endmodule

// File: tb/csar_ctrl_test.sv
module csar_ctrl_test;
   localparam int NB  = 12;
   localparam int NCM = 2;
   localparam int NM  = NB - NCM;
   localparam int SW  = 4*NCM + 2*NM;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic cmp = 1'b0;
   logic vld = 1'b0;
   logic [2*NCM-1:0] split_p, split_n;
   logic [NM-1:0]    mono_p, mono_n;
   logic [NB-1:0]    result;
   logic             done;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   csar_ctrl #(.NBITS(NB), .N_CM(NCM)) uut (
      .clk(clk), .rst(rst), .start_i(start), .cmp_i(cmp), .cmp_vld_i(vld),
      .split_p_o(split_p), .split_n_o(split_n),
      .mono_p_o(mono_p), .mono_n_o(mono_n),
      .result_o(result), .done_o(done)
   );

   // k = lowest bit already decided; k = NB means none decided
   function automatic logic [SW-1:0] exp_sw(input int t, input int k);
      logic [NB-1:0]    c = NB'(t);
      logic [2*NCM-1:0] sp, sn;
      logic [NM-1:0]    mp, mn;
      for (int j = 0; j < NCM; j++) begin
         if (NM + j >= k) begin
            sp[2*j +: 2] = {2{~c[NM+j]}};
            sn[2*j +: 2] = {2{c[NM+j]}};
         end else begin
            sp[2*j +: 2] = 2'b01;
            sn[2*j +: 2] = 2'b01;
         end
      end
      for (int b = 0; b < NM; b++) begin
         if (b >= k) begin
            mp[b] = ~c[b];
            mn[b] = c[b];
         end else begin
            mp[b] = (b == NM - 1);
            mn[b] = (b == NM - 1);
         end
      end
      return {sp, sn, mp, mn};
   endfunction

   task automatic check_sw(input string req, input int t, input int k);
      logic [SW-1:0] act = {split_p, split_n, mono_p, mono_n};
      logic [SW-1:0] ex  = exp_sw(t, k);
      n_run++;
      if (act !== ex) begin
         n_fail++;
         $display("FAIL %s switches code=%0h k=%0d actual=%h expected=%h", req, t, k, act, ex);
      end
   endtask

   task automatic check_val(input string req, input int act, input int ex);
      n_run++;
      if (act != ex) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, ex);
      end
   endtask

   task automatic convert(input int t);
      logic [NB-1:0] c = NB'(t);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int i = NB - 1; i >= 0; i--) begin
         if ((t + i) % 5 == 0) begin
            vld = 1'b0; cmp = ~c[i]; start = ((t + i) % 7 == 0);
            @(negedge clk) start = 1'b0;
            check_sw("R2/R7 no strobe", t, i + 1);
         end
         vld = 1'b1; cmp = c[i];
         @(negedge clk) vld = 1'b0;
         if (i >= NM)          check_sw("R3", t, i);
         else if (i == NM - 1) check_sw("R4", t, i);
         else                  check_sw("R5", t, i);
      end
      check_val("R6 done", int'(done), 1);
      check_val("R2 result", int'(result), t);
      if (t % 64 == 0) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check_val("R6 done falls", int'(done), 0);
      check_sw("R1 rest after done", t, NB);
      if (t % 64 == 0) begin
         vld = 1'b1; cmp = 1'b1;
         @(negedge clk) vld = 1'b0;
         check_sw("R7/R8 idle strobe", t, NB);
         check_val("R6 result held", int'(result), t);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check_sw("R1 reset", 0, NB);
      check_val("R1 done", int'(done), 0);
      check_val("R1 result", int'(result), 0);
      // R8: strobe while idle
      vld = 1'b1; cmp = 1'b0;
      @(negedge clk) vld = 1'b0;
      check_sw("R8 idle strobe", 0, NB);
      // R9: reset in the middle of a conversion
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int i = 0; i < 5; i++) begin
         vld = 1'b1; cmp = 1'b1;
         @(negedge clk) vld = 1'b0;
      end
      check_sw("R9 before reset", NB'(12'hFFF), NB - 5);
      rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      check_sw("R9 rest", 0, NB);
      check_val("R9 done", int'(done), 0);
      vld = 1'b1; cmp = 1'b1;
      @(negedge clk) vld = 1'b0;
      check_sw("R9 idle after reset", 0, NB);
      for (int t = 0; t < (1 << NB); t++) convert(t);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule